// File: doc/BRIEF.md
# Scan Load-Capture-Unload Test Sequencer

This block runs one complete structural test of a single internal gate inside a circuit whose flip-flops have been replaced by scan cells joined in one serial chain. On a start pulse it raises scan enable and feeds a stored test pattern bit by bit into the chain. It then lowers scan enable for exactly one functional clock while it drives held primary-input values. That clock lets the gate under test write its result into a chain cell. Scan enable then goes high again for just enough cycles to move that cell's content to the chain's serial output.

One cycle later the block samples the serial output and compares it with the expected response. It then reports done together with a pass flag. Both flags stay put until the next accepted start. The load and unload lengths are parameters that match the chain position of the observed cell. The start, pattern, expected bit and primary-input values are plain control inputs that are latched when a test begins. No valid/ready handshake exists, because every transfer follows the fixed test schedule and never waits on back-pressure.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, scan_en, scan_in, done and pass are all 0. Done stays 0 whenever scan_en is 1.
- R2: A start accepted at a clock edge makes scan_en 1 for exactly LOAD_LEN cycles. During the k-th of these cycles (k from 0), scan_in carries pattern bit k, so bit 0 enters the chain first. Outside the load phase, scan_in is 0.
- R3: After the load phase, scan_en is 0 for exactly one cycle (the capture clock) before it returns to 1.
- R4: After the capture cycle, scan_en is 1 for exactly UNLOAD_LEN cycles and then returns to 0.
- R5: In the cycle after the unload phase, scan_out is sampled. Done rises LOAD_LEN+UNLOAD_LEN+2 clock edges after the start edge. Pass is 1 exactly when the sampled bit equals the expected bit that was latched at start.
- R6: Done and pass hold their values until the next accepted start. A start while done is 1 clears done and begins a new test.
- R7: A start pulse that arrives during a test in progress is ignored. It does not disturb the scan_in sequence, the timing of done, or the latched pattern, expected bit and primary inputs.
- R8: pi_out takes the value of pi_in only at an accepted start and is stable at all other times, including the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the scan chain |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test when idle or done |
| pattern | input | LOAD_LEN | Serial load bits, bit 0 shifted first |
| expect_bit | input | 1 | Fault-free value of the observed bit |
| pi_in | input | PI_W | Primary-input values for the capture clock |
| scan_out | input | 1 | Serial output of the chain |
| scan_en | output | 1 | 1 = chain shifts, 0 = functional capture |
| scan_in | output | 1 | Serial input to the chain |
| pi_out | output | PI_W | Held primary-input values |
| done | output | 1 | Test finished, held until next start |
| pass | output | 1 | Observed bit matched the expected bit |

## Verification
Two functions can meet in one cycle. A start request can arrive while the sequencer is busy shifting or capturing. It can also arrive in the very cycle that done is high, where it must restart the test. The bench raises start in the middle of the load phase, with a changed pattern, expected bit and primary-input values on the pins. It then checks that the scan_in bits, the capture values and the cycle of done all follow the first request. It also issues a start directly from the done state and checks that done drops and a fresh load begins at once.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPTURE,
    ST_UNLOAD,
    ST_COMPARE,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/seq_step_counter.sv
module seq_step_counter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] final_val,
  output logic          at_final
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign at_final = (cnt == final_val);
endmodule

// File: rtl/seq_pattern_feed.sv
module seq_pattern_feed #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [N-1:0] bits_in,
  output logic         head
);
  logic [N-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= bits_in;
    else if (shift) sh <= sh >> 1;
  end

  assign head = sh[0];
endmodule

// File: rtl/seq_verdict.sv
module seq_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic expect_in,
  input  logic judge,
  input  logic observed,
  output logic done,
  output logic pass
);
  logic exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else if (arm) begin
      exp_q <= expect_in;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else if (judge) begin
      done  <= 1'b1;
      pass  <= (observed == exp_q);
    end
  end
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int LOAD_LEN   = 3,
  parameter int UNLOAD_LEN = 1,
  parameter int PI_W       = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LOAD_LEN-1:0] pattern,
  input  logic                expect_bit,
  input  logic [PI_W-1:0]     pi_in,
  input  logic                scan_out,
  output logic                scan_en,
  output logic                scan_in,
  output logic [PI_W-1:0]     pi_out,
  output logic                done,
  output logic                pass
);
  localparam int MAXLEN = (LOAD_LEN > UNLOAD_LEN) ? LOAD_LEN : UNLOAD_LEN;
  localparam int CW     = $clog2(MAXLEN + 1);

  seq_state_t state, nxt;
  logic       accept, at_final, head;
  logic [CW-1:0] final_val;
  logic [PI_W-1:0] pi_q;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE, ST_DONE: if (accept) nxt = ST_LOAD;
      ST_LOAD:          if (at_final) nxt = ST_CAPTURE;
      ST_CAPTURE:       nxt = ST_UNLOAD;
      ST_UNLOAD:        if (at_final) nxt = ST_COMPARE;
      ST_COMPARE:       nxt = ST_DONE;
      default:          nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pi_q  <= '0;
    end else begin
      state <= nxt;
      if (accept) pi_q <= pi_in;
    end
  end

  assign final_val = (state == ST_UNLOAD) ? CW'(UNLOAD_LEN - 1) : CW'(LOAD_LEN - 1);

  seq_step_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept || state == ST_CAPTURE),
    .step     (state == ST_LOAD || state == ST_UNLOAD),
    .final_val(final_val),
    .at_final (at_final)
  );

  seq_pattern_feed #(.N(LOAD_LEN)) u_feed (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .shift  (state == ST_LOAD),
    .bits_in(pattern),
    .head   (head)
  );

  seq_verdict u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (accept),
    .expect_in(expect_bit),
    .judge    (state == ST_COMPARE),
    .observed (scan_out),
    .done     (done),
    .pass     (pass)
  );

  assign scan_en = (state == ST_LOAD) || (state == ST_UNLOAD);
  assign scan_in = (state == ST_LOAD) && head;
  assign pi_out  = pi_q;
endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
  parameter int PI_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            scan_en,
  input logic            scan_in,
  input logic [PI_W-1:0] pi_out,
  input logic            done
);
  // R2
  scan_in_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !scan_in);
  // R3
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |=> (scan_en || done));
  // R1
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> !done);
  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R8
  pi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(pi_out));
  // R5
  done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !scan_en);
endmodule

bind scan_test_seq scan_test_seq_chk #(.PI_W(PI_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .scan_en(scan_en),
  .scan_in(scan_in),
  .pi_out (pi_out),
  .done   (done)
);

// File: tb/scan_test_seq_bench.sv
module scan_test_seq_bench;
  localparam int LL = 3;
  localparam int UL = 1;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LL-1:0] pattern = '0;
  logic expect_bit = 1'b0;
  logic [PW-1:0] pi_in = '0;
  logic scan_out;
  logic scan_en, scan_in, done, pass;
  logic [PW-1:0] pi_out;
  logic fault = 1'b0;
  logic x1, x2, x3;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // three-cell chain model; cell 2 captures the AND of cells 1 and 3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1 <= 1'b0; x2 <= 1'b0; x3 <= 1'b0;
    end else if (scan_en) begin
      x1 <= scan_in; x2 <= x1; x3 <= x2;
    end else begin
      x1 <= pi_out[0]; x2 <= (x1 & x3) ^ fault; x3 <= pi_out[1];
    end
  end
  assign scan_out = x3;

  scan_test_seq #(.LOAD_LEN(LL), .UNLOAD_LEN(UL), .PI_W(PW)) u_scan_test_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
    .expect_bit(expect_bit), .pi_in(pi_in), .scan_out(scan_out),
    .scan_en(scan_en), .scan_in(scan_in), .pi_out(pi_out),
    .done(done), .pass(pass)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one test; optional busy start injected in load cycle 1
  task automatic run_one(input logic [LL-1:0] p, input logic e,
                         input logic [PW-1:0] pv, input logic f, input bit poke);
    logic ref_and, want;
    @(negedge clk);
    pattern = p; expect_bit = e; pi_in = pv; fault = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R6: accepted start clears done
    chk(done == 1'b0, "R6", done, 0);
    for (int k = 0; k < LL; k++) begin
      // R2
      chk(scan_en == 1'b1, "R2", scan_en, 1);
      chk(scan_in == p[k], "R2", scan_in, p[k]);
      if (poke && k == 0) begin
        pattern = ~p; expect_bit = ~e; pi_in = ~pv; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    // R3 capture cycle, R8 held inputs
    chk(scan_en == 1'b0, "R3", scan_en, 0);
    chk(pi_out == pv, "R8", pi_out, pv);
    @(negedge clk);
    for (int k = 0; k < UL; k++) begin
      chk(scan_en == 1'b1, "R4", scan_en, 1);
      @(negedge clk);
    end
    chk(scan_en == 1'b0 && done == 1'b0, "R5", done, 0);
    @(negedge clk);
    ref_and = (p[0] & p[LL-1]) ^ f;
    want = (ref_and == e);
    chk(done == 1'b1, "R5", done, 1);
    chk(pass == want, "R5", pass, want);
    chk(pi_out == pv, "R7", pi_out, pv);
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1 && pass == want, "R6", {done, pass}, {1'b1, want});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scan_en == 0 && scan_in == 0 && done == 0 && pass == 0, "R1",
        {scan_en, scan_in, done, pass}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && scan_en == 0, "R1", {done, scan_en}, 0);
    for (int p = 0; p < (1 << LL); p++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++)
          for (int v = 0; v < (1 << PW); v++)
            run_one(LL'(p), e[0], PW'(v), f[0], 1'b0);
    // R7 busy starts with altered inputs
    run_one(3'b101, 1'b1, 2'b01, 1'b0, 1'b1);
    run_one(3'b001, 1'b0, 2'b10, 1'b1, 1'b1);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule